// File: doc/BRIEF.md
# SD Card Command Line Engine

This block drives a single command onto the SD/MMC command line and, when the command type calls for it, collects the card's reply. A request is made of a 6-bit index, a 32-bit argument, a 2-bit reply kind and an optional wait-for-busy flag, and it is handed over by pulsing `issue` while the engine is idle. The engine builds the 48-bit frame and computes its CRC7. It shifts the frame out one bit per card-clock pulse (`bit_tick`), then watches the line for a reply start bit. It captures a 48-bit or 136-bit reply and checks the reply CRC when the reply kind asks for it.

Results appear as sticky status flags: command sent, reply received, reply CRC error, reply timeout and busy release. These are cleared by pulsing ones on `clear`. Two live bits show that a command is in flight and that the card is holding data line 0 low after a reply. An interrupt line is the OR of every status bit whose enable bit is set. Reply contents land in four 32-bit words that keep their value until a later reply overwrites them.

Top module: `sd_cmd_engine`

## Requirements
- R1: A pulse on `issue` is taken only when status bits 6 (in flight) and 5 (busy) are both low, and status bit 6 is high from the next cycle until a completion flag is set. An `issue` pulse while either bit is high has no effect.
- R2: The frame is, most significant bit first: 0, 1, the 6-bit index, the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, zero seed) over those 40 bits, then 1. Each bit is shown on `cmd_out` with `cmd_oe` high, from the accepting cycle for the first bit, and it advances at each `bit_tick`. Otherwise `cmd_oe` is low and `cmd_out` is 1.
- R3: With reply kind 00, status bit 3 (sent) is set at the `bit_tick` that ends the 48th bit, and status bit 6 drops in the same cycle.
- R4: With reply kind other than 00, `cmd_in` is sampled at each `bit_tick` after the frame. A 0 seen on any of the first 64 samples starts reception. If all 64 samples are 1, status bit 1 (timeout) is set at the 64th.
- R5: Reply kinds 01 and 10 take 48 bits counting the start bit. `resp0` gets bits 39..8 of the reply (the 32 bits that follow the 8 header bits), and `resp1` to `resp3` keep their value.
- R6: For kind 01, a CRC7 over the first 40 reply bits that differs from reply bits 7..1 sets status bit 0 (CRC error) instead of status bit 2 (reply received). Kinds 10 and 11 never set bit 0 and always set bit 2 when the reply ends.
- R7: Reply kind 11 takes 136 bits. The last 128 bits received fill `resp0` through `resp3`, with the first of them in `resp0` bit 31.
- R8: When wait-for-busy was given with the request and bit 2 is set, status bit 5 (busy) is high until a `bit_tick` samples `dat0_in` high. At that tick busy drops and status bit 4 (busy released) is set.
- R9: Status bits 4..0 are sticky. A 1 on `clear` bit n clears status bit n unless the same cycle sets it. After reset every status bit is 0.
- R10: `irq` is high exactly when some status bit and the matching `irq_en` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per card clock period |
| issue | input | 1 | Start a command with the request fields |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_kind | input | 2 | 00 none, 01 short with CRC, 10 short without CRC, 11 long |
| wait_busy | input | 1 | Track data line 0 busy after the reply |
| cmd_in | input | 1 | Command line input from the card |
| dat0_in | input | 1 | Data line 0 input |
| clear | input | 5 | Write-one-to-clear for status bits 4..0 |
| irq_en | input | 7 | Interrupt enable per status bit |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| resp0 | output | 32 | Reply word 0 |
| resp1 | output | 32 | Reply word 1 |
| resp2 | output | 32 | Reply word 2 |
| resp3 | output | 32 | Reply word 3 |
| status | output | 7 | 0 CRC error, 1 timeout, 2 received, 3 sent, 4 busy released, 5 busy, 6 in flight |
| irq | output | 1 | Interrupt request |

## Verification
Status bit 6 rises one clock after an accepted `issue`. Every flag and reply word changes in the clock of the `bit_tick` that completes its event: the 48th frame bit, the 64th empty sample, the last reply bit, or the first high sample of data line 0. `irq` follows the status and enables in the same cycle. The bench model moves on the same edges from the same sampled inputs, and every output is compared a quarter period after each rising edge. So each result is checked in the exact cycle it is due and in every cycle around it.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int RESP_TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_tick,
  input  logic        issue,
  input  logic [5:0]  cmd_index,
  input  logic [31:0] cmd_arg,
  input  logic [1:0]  resp_kind,
  input  logic        wait_busy,
  input  logic        cmd_in,
  input  logic        dat0_in,
  input  logic [4:0]  clear,
  input  logic [6:0]  irq_en,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic [31:0] resp0,
  output logic [31:0] resp1,
  output logic [31:0] resp2,
  output logic [31:0] resp3,
  output logic [6:0]  status,
  output logic        irq
);
  localparam int FRAME_LEN = 48;
  localparam int LONG_LEN  = 136;
  localparam int CRC_SPAN  = 40;
  localparam int CW = $clog2((RESP_TIMEOUT > LONG_LEN) ? RESP_TIMEOUT : LONG_LEN) + 1;

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_BUSY} st_t;

  st_t          st;
  logic [47:0]  tx_sh;
  logic [CW-1:0] cnt;
  logic [1:0]   kind_q;
  logic         wb_q;
  logic [6:0]   crc_q;
  logic [127:0] rx_sh;
  logic [4:0]   flg;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_of(input logic [39:0] v);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, v[i]);
    return c;
  endfunction

  logic [39:0]  hdr;
  logic [127:0] rx_nxt;
  logic         last_tx, last_rx, fin, crc_bad;
  logic         s_crc, s_to, s_done, s_sent, s_bend;

  assign hdr     = {2'b01, cmd_index, cmd_arg};
  assign rx_nxt  = {rx_sh[126:0], cmd_in};
  assign last_tx = cnt == CW'(FRAME_LEN - 1);
  assign last_rx = cnt == ((kind_q == 2'b11) ? CW'(LONG_LEN - 1) : CW'(FRAME_LEN - 1));
  assign fin     = st == S_RX && bit_tick && last_rx;
  assign crc_bad = kind_q == 2'b01 && rx_nxt[7:1] != crc_q;

  assign s_sent = st == S_TX && bit_tick && last_tx && kind_q == 2'b00;
  assign s_to   = st == S_WAIT && bit_tick && cmd_in && cnt == CW'(RESP_TIMEOUT - 1);
  assign s_crc  = fin && crc_bad;
  assign s_done = fin && !crc_bad;
  assign s_bend = st == S_BUSY && bit_tick && dat0_in;

  assign cmd_oe  = st == S_TX;
  assign cmd_out = (st == S_TX) ? tx_sh[47] : 1'b1;
  assign status  = {st == S_TX || st == S_WAIT || st == S_RX, st == S_BUSY, flg};
  assign irq     = |(status & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tx_sh  <= '0;
      cnt    <= '0;
      kind_q <= '0;
      wb_q   <= 1'b0;
      crc_q  <= '0;
      rx_sh  <= '0;
    end else begin
      case (st)
        S_IDLE: if (issue) begin
          tx_sh  <= {hdr, crc7_of(hdr), 1'b1};
          cnt    <= '0;
          kind_q <= resp_kind;
          wb_q   <= wait_busy;
          st     <= S_TX;
        end
        S_TX: if (bit_tick) begin
          tx_sh <= {tx_sh[46:0], 1'b1};
          if (last_tx) begin
            cnt <= '0;
            st  <= (kind_q == 2'b00) ? S_IDLE : S_WAIT;
          end else cnt <= cnt + 1'b1;
        end
        S_WAIT: if (bit_tick) begin
          if (!cmd_in) begin
            cnt   <= CW'(1);
            crc_q <= '0;
            st    <= S_RX;
          end else if (cnt == CW'(RESP_TIMEOUT - 1)) st <= S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        S_RX: if (bit_tick) begin
          rx_sh <= rx_nxt;
          if (cnt < CW'(CRC_SPAN)) crc_q <= crc7_step(crc_q, cmd_in);
          if (last_rx) st <= (!crc_bad && wb_q) ? S_BUSY : S_IDLE;
          else cnt <= cnt + 1'b1;
        end
        S_BUSY: if (bit_tick && dat0_in) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp0 <= '0;
      resp1 <= '0;
      resp2 <= '0;
      resp3 <= '0;
    end else if (fin) begin
      if (kind_q == 2'b11) begin
        resp0 <= rx_nxt[127:96];
        resp1 <= rx_nxt[95:64];
        resp2 <= rx_nxt[63:32];
        resp3 <= rx_nxt[31:0];
      end else resp0 <= rx_nxt[39:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg <= '0;
    else flg <= (flg & ~clear) | {s_bend, s_sent, s_done, s_to, s_crc};
  end
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       issue,
  input logic       cmd_oe,
  input logic [4:0] clear,
  input logic [6:0] irq_en,
  input logic [6:0] status,
  input logic       irq
);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !status[6] && !status[5]) |=> status[6]);

  p_oe_inflight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> status[6]);

  p_sent_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> !status[6]);

  p_timeout_after_flight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(status[6]));

  p_crc_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> !$rose(status[2]));

  p_release_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> ($past(status[5]) && !status[5]));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !clear[1]) |=> status[1]);

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 7'd0) |-> !irq);
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .cmd_oe(cmd_oe),
  .clear(clear), .irq_en(irq_en), .status(status), .irq(irq)
);

// File: tb/sd_cmd_engine_tb.sv
module sd_cmd_engine_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, bit_tick = 0, issue = 0, wait_busy = 0;
  logic cmd_in = 1, dat0_in = 1;
  logic [5:0] cmd_index = 0;
  logic [31:0] cmd_arg = 0;
  logic [1:0] resp_kind = 0;
  logic [4:0] clear = 0;
  logic [6:0] irq_en = 0;
  logic cmd_out, cmd_oe, irq;
  logic [31:0] resp0, resp1, resp2, resp3;
  logic [6:0] status;

  sd_cmd_engine u_dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, tdiv = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [39:0] v);
    logic [6:0] c = 0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  // behavioural reference
  int ms = 0, wt = 0, mkind = 0, len = 0;
  bit mbw = 0;
  bit txq[$], rxq[$], card_q[$];
  logic [31:0] mr0 = 0, mr1 = 0, mr2 = 0, mr3 = 0;
  logic [4:0] mf = 0, ms_set;
  logic [135:0] mv;
  logic [47:0] fr;
  logic mbad;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mf = 0; mr0 = 0; mr1 = 0; mr2 = 0; mr3 = 0;
      txq.delete(); rxq.delete();
    end else begin
      ms_set = 0;
      if (ms == 0) begin
        if (issue) begin
          fr = {2'b01, cmd_index, cmd_arg, crc7({2'b01, cmd_index, cmd_arg}), 1'b1};
          txq.delete();
          for (int i = 47; i >= 0; i--) txq.push_back(fr[i]);
          mkind = resp_kind; mbw = wait_busy; ms = 1;
        end
      end else if (bit_tick) begin
        case (ms)
          1: begin
            void'(txq.pop_front());
            if (txq.size() == 0) begin
              if (mkind == 0) begin ms_set[3] = 1; ms = 0; end
              else begin ms = 2; wt = 0; end
            end
          end
          2: begin
            if (card_q.size() > 0) void'(card_q.pop_front());
            if (!cmd_in) begin ms = 3; rxq.delete(); rxq.push_back(1'b0); end
            else begin
              wt++;
              if (wt == 64) begin ms_set[1] = 1; ms = 0; end
            end
          end
          3: begin
            if (card_q.size() > 0) void'(card_q.pop_front());
            rxq.push_back(cmd_in);
            len = (mkind == 3) ? 136 : 48;
            if (rxq.size() == len) begin
              mv = 0;
              for (int i = 0; i < len; i++) mv[len-1-i] = rxq[i];
              mbad = 0;
              if (mkind == 3) begin
                mr0 = mv[127:96]; mr1 = mv[95:64]; mr2 = mv[63:32]; mr3 = mv[31:0];
              end else begin
                mr0 = mv[39:8];
                mbad = (mkind == 1) && (mv[7:1] != crc7(mv[47:8]));
              end
              if (mbad) begin ms_set[0] = 1; ms = 0; end
              else begin ms_set[2] = 1; ms = mbw ? 4 : 0; end
            end
          end
          4: if (dat0_in) begin ms_set[4] = 1; ms = 0; end
          default: ms = 0;
        endcase
      end
      mf = (mf & ~clear) | ms_set;
    end
  end

  logic [6:0] exp_st;
  always @(posedge clk) begin
    #(CLK_P/4);
    cyc++;
    exp_st = {ms >= 1 && ms <= 3, ms == 4, mf};
    chk("R2 cmd_oe", cmd_oe, ms == 1);
    chk("R2 cmd_out", cmd_out, (ms == 1) ? txq[0] : 1'b1);
    chk("R1 in flight", status[6], exp_st[6]);
    chk("R3 sent", status[3], exp_st[3]);
    chk("R4 timeout", status[1], exp_st[1]);
    chk("R6 crc err", status[0], exp_st[0]);
    chk("R6 received", status[2], exp_st[2]);
    chk("R8 busy", status[5], exp_st[5]);
    chk("R8 released", status[4], exp_st[4]);
    chk("R5 resp0", resp0, mr0);
    chk("R7 resp1", resp1, mr1);
    chk("R7 resp2", resp2, mr2);
    chk("R7 resp3", resp3, mr3);
    chk("R10 irq", irq, |(exp_st & irq_en));
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    bit_tick <= (tdiv == 0);
    cmd_in <= (card_q.size() > 0) ? card_q[0] : 1'b1;
  end

  task automatic load_short(input int dly, input logic [5:0] idx, input logic [31:0] c, input bit good);
    logic [39:0] h = {2'b00, idx, c};
    logic [47:0] b = {h, good ? crc7(h) : crc7(h) ^ 7'h01, 1'b1};
    card_q.delete();
    for (int i = 0; i < dly; i++) card_q.push_back(1'b1);
    for (int i = 47; i >= 0; i--) card_q.push_back(b[i]);
  endtask

  task automatic load_long(input logic [127:0] c);
    card_q.delete();
    card_q.push_back(1'b1); card_q.push_back(1'b1);
    card_q.push_back(1'b0); card_q.push_back(1'b0);
    for (int i = 0; i < 6; i++) card_q.push_back(1'b1);
    for (int i = 127; i >= 0; i--) card_q.push_back(c[i]);
  endtask

  task automatic send(input int k, input logic [5:0] idx, input logic [31:0] a, input bit wb);
    @(negedge clk);
    resp_kind = k[1:0]; cmd_index = idx; cmd_arg = a; wait_busy = wb; issue = 1;
    @(negedge clk);
    issue = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (ms != 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic clr_all();
    @(negedge clk); clear = 5'h1F;
    @(negedge clk); clear = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset status", status, 0);
    chk("R2 reset cmd_oe", cmd_oe, 0);
    irq_en = 7'h7F;

    send(0, 6'd0, 32'h0, 0); wait_idle();
    chk("R3 sent flag", status[3], 1);
    clr_all();
    chk("R9 cleared", status, 0);

    load_short(5, 6'd17, 32'hA5C3_0F12, 1); send(1, 6'd17, 32'h1234_5678, 0); wait_idle();
    chk("R5 short word", resp0, 32'hA5C3_0F12);
    chk("R6 good crc", status[2:0], 3'b100);
    clr_all();

    load_short(2, 6'd8, 32'h0000_01AA, 0); send(1, 6'd8, 32'h0000_01AA, 0); wait_idle();
    chk("R6 bad crc", status[2:0], 3'b001);
    clr_all();

    load_short(3, 6'd55, 32'hDEAD_BEEF, 0); send(2, 6'd55, 32'h0, 0); wait_idle();
    chk("R6 no crc check", status[2:0], 3'b100);
    clr_all();

    load_long(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211);
    send(3, 6'd2, 32'h0, 0); wait_idle();
    chk("R7 long w0", resp0, 32'h0123_4567);
    chk("R7 long w3", resp3, 32'h7654_3211);
    load_short(1, 6'd3, 32'h5555_AAAA, 1); send(1, 6'd3, 32'h0, 0); wait_idle();
    chk("R5 keeps w1", resp1, 32'h89AB_CDEF);
    clr_all();

    card_q.delete(); send(1, 6'd9, 32'h0, 0); wait_idle();
    chk("R4 timeout", status[1], 1);
    clr_all();
    load_short(63, 6'd13, 32'h1357_9BDF, 1); send(1, 6'd13, 32'h0, 0); wait_idle();
    chk("R4 start at 64th sample", status[2:1], 2'b10);
    clr_all();
    load_short(64, 6'd13, 32'h2468_ACE0, 1); send(1, 6'd13, 32'h0, 0); wait_idle();
    chk("R4 start too late", status[2:1], 2'b01);
    card_q.delete();
    clr_all();

    dat0_in = 0;
    load_short(4, 6'd7, 32'h0000_0900, 1); send(1, 6'd7, 32'h0, 1);
    do @(negedge clk); while (ms != 4);
    repeat (30) @(negedge clk);
    chk("R8 busy held", status[5], 1);
    dat0_in = 1; wait_idle();
    chk("R8 released", status[5:4], 2'b01);
    clr_all();
    load_short(4, 6'd7, 32'h0000_0900, 1); send(1, 6'd7, 32'h0, 1); wait_idle();
    chk("R8 released at once", status[4], 1);
    clr_all();

    send(0, 6'd5, 32'hCAFE_0001, 0);
    repeat (10) @(negedge clk);
    send(1, 6'd6, 32'hFFFF_FFFF, 0); wait_idle();
    chk("R1 ignored issue", status[3:2], 2'b10);

    irq_en = 0; @(negedge clk);
    chk("R10 irq masked", irq, 0);
    irq_en = 7'h08; @(negedge clk);
    chk("R10 irq sent", irq, 1);
    irq_en = 7'h01; @(negedge clk);
    chk("R10 irq other", irq, 0);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule